// File: doc/BRIEF.md
# Mark/Space Carrier Modulator Gate

This block turns a free-running carrier into a keyed output. Each modulation cycle has a mark part, in which the carrier input is passed to the output, and then a space part, in which the output is held low. Both lengths are counted in ticks of a divide-by-8 prescaler on the module clock. The mark part lasts one tick more than its programmed value. The space part lasts exactly its programmed value, and that value may be zero.

The block runs only in time mode, which requires the enable to be high and both the baseband and frequency-shift selects to be low. Every completed cycle sets a sticky end-of-cycle flag. A dedicated strobe clears the flag, and the flag raises an interrupt request when interrupts are enabled. The programmed lengths are captured internally when the block starts and again at each cycle end, so software may rewrite them at any time without disturbing the cycle in progress.

Top module: `carrier_gate_mod`

## Requirements
- R1: The block runs only when `mod_en`=1, `baseband_sel`=0 and `fsk_sel`=0. In any other setting `mod_out` stays 0 and no end-of-cycle event occurs.
- R2: All interval lengths are whole multiples of 8 module clocks.
- R3: Counted from the first clock edge at which the block samples itself active, the mark part lasts 8×(`mark_val`+1) clocks.
- R4: The space part lasts 8×`space_val` clocks. With `space_val`=0 there is no low gap, and the cycle ends as the mark part ends.
- R5: During the mark part `mod_out` equals `carrier_in` in the same cycle. During the space part `mod_out` is 0.
- R6: `eoc_flag` goes to 1 on the clock edge that ends each mark+space cycle and stays 1 until it is cleared.
- R7: `eoc_clr`=1 at a clock edge clears `eoc_flag`. If an end-of-cycle event falls on the same edge, the flag stays 1.
- R8: `irq` equals `eoc_flag` AND `irq_en`, combinationally.
- R9: The mark and space values are captured when the block starts and at each end of cycle. A change to either value during a cycle takes effect only from the next cycle.
- R10: Dropping the block out of time mode forces `mod_out` to 0 in the same cycle. The next start begins a complete new mark part.
- R11: After synchronous reset `mod_out`, `eoc_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Modulator enable |
| baseband_sel | input | 1 | Baseband select, must be 0 for time mode |
| fsk_sel | input | 1 | Frequency-shift select, must be 0 for time mode |
| irq_en | input | 1 | Interrupt enable |
| mark_val | input | 16 | Mark length value (ticks minus one) |
| space_val | input | 16 | Space length value in ticks |
| carrier_in | input | 1 | Carrier from the carrier generator |
| eoc_clr | input | 1 | Clear strobe for the end-of-cycle flag |
| mod_out | output | 1 | Gated carrier output |
| eoc_flag | output | 1 | Sticky end-of-cycle flag |
| irq | output | 1 | Interrupt request |

## Verification
Most internal faults show up at the ports within one tick. A wrong prescaler or counter value shifts the edge where `mod_out` stops following the carrier, so the measured run lengths stop being multiples of 8 or miss 8×(value+1) and 8×value. A stale or early-loaded space value moves the `eoc_flag` rising edge by whole ticks within the same cycle, or in the following cycle when a value changes mid-cycle. A sequencer that is not returned to idle on disable shows a shortened first mark after the next start.

// File: rtl/cmg_pkg.sv
package cmg_pkg;

    localparam int VAL_W    = 16;
    localparam int TICK_DIV = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MARK  = 2'd1,
        PH_SPACE = 2'd2
    } phase_e;

    typedef struct packed {
        logic en;
        logic base;
        logic fsk;
    } mode_t;

    function automatic logic time_mode_on(mode_t m);
        return m.en & ~m.base & ~m.fsk;
    endfunction

endpackage

// File: rtl/cmg_prescaler.sv
module cmg_prescaler #(
    parameter int DIV = cmg_pkg::TICK_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = run_i & (div_q == LAST);

    assert_tick_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (div_q == '0));
    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (div_q == '0));

endmodule

// File: rtl/cmg_sequencer.sv
module cmg_sequencer
    import cmg_pkg::*;
#(
    parameter int VAL_W = cmg_pkg::VAL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic             tick_i,
    input  logic [VAL_W-1:0] mark_i,
    input  logic [VAL_W-1:0] space_i,
    output phase_e           phase_o,
    output logic             eoc_o
);
    localparam int CNT_W = VAL_W + 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [VAL_W-1:0]  space_sh;
    } seq_t;

    seq_t cur, nxt;
    logic last_tick;
    logic cyc_end;
    logic [CNT_W-1:0] mark_load;

    assign mark_load = {1'b0, mark_i} + ONE;
    assign last_tick = tick_i & (cur.cnt == ONE);
    assign cyc_end   = active_i & last_tick &
                       ((cur.phase == PH_SPACE) ||
                        ((cur.phase == PH_MARK) && (cur.space_sh == '0)));

    always_comb begin
        nxt = cur;
        if (!active_i) begin
            nxt.phase = PH_IDLE;
            nxt.cnt   = '0;
        end else begin
            unique case (cur.phase)
                PH_IDLE: begin
                    nxt.phase    = PH_MARK;
                    nxt.cnt      = mark_load;
                    nxt.space_sh = space_i;
                end
                PH_MARK: begin
                    if (cyc_end) begin
                        nxt.cnt      = mark_load;
                        nxt.space_sh = space_i;
                    end else if (last_tick) begin
                        nxt.phase = PH_SPACE;
                        nxt.cnt   = {1'b0, cur.space_sh};
                    end else if (tick_i) begin
                        nxt.cnt = cur.cnt - ONE;
                    end
                end
                PH_SPACE: begin
                    if (cyc_end) begin
                        nxt.phase    = PH_MARK;
                        nxt.cnt      = mark_load;
                        nxt.space_sh = space_i;
                    end else if (tick_i) begin
                        nxt.cnt = cur.cnt - ONE;
                    end
                end
                default: begin
                    nxt.phase = PH_IDLE;
                    nxt.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.phase    <= PH_IDLE;
            cur.cnt      <= '0;
            cur.space_sh <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign phase_o = cur.phase;
    assign eoc_o   = cyc_end;

    assert_cnt_live_R3: assert property (@(posedge clk) disable iff (rst)
        (cur.phase != PH_IDLE) |-> (cur.cnt != '0));
    assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> (cur.phase == PH_IDLE));
    assert_restart_mark_R9: assert property (@(posedge clk) disable iff (rst)
        eoc_o |=> (cur.phase != PH_SPACE));
    assert_space_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        (cur.phase == PH_SPACE) |-> (cur.space_sh != '0));

endmodule

// File: rtl/cmg_eoc_flag.sv
module cmg_eoc_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/carrier_gate_mod.sv
module carrier_gate_mod
    import cmg_pkg::*;
#(
    parameter int VAL_W = cmg_pkg::VAL_W,
    parameter int DIV   = cmg_pkg::TICK_DIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_en,
    input  logic             baseband_sel,
    input  logic             fsk_sel,
    input  logic             irq_en,
    input  logic [VAL_W-1:0] mark_val,
    input  logic [VAL_W-1:0] space_val,
    input  logic             carrier_in,
    input  logic             eoc_clr,
    output logic             mod_out,
    output logic             eoc_flag,
    output logic             irq
);
    mode_t  mode;
    logic   active;
    logic   running;
    logic   tick;
    logic   eoc;
    phase_e phase;

    assign mode    = '{en: mod_en, base: baseband_sel, fsk: fsk_sel};
    assign active  = time_mode_on(mode);
    assign running = active & (phase != PH_IDLE);

    cmg_prescaler #(.DIV(DIV)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .run_i  (running),
        .tick_o (tick)
    );

    cmg_sequencer #(.VAL_W(VAL_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .active_i (active),
        .tick_i   (tick),
        .mark_i   (mark_val),
        .space_i  (space_val),
        .phase_o  (phase),
        .eoc_o    (eoc)
    );

    cmg_eoc_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .set_i    (eoc),
        .clr_i    (eoc_clr),
        .irq_en_i (irq_en),
        .flag_o   (eoc_flag),
        .irq_o    (irq)
    );

    assign mod_out = active & (phase == PH_MARK) & carrier_in;

    assert_no_event_off_R1: assert property (@(posedge clk) disable iff (rst)
        !active |-> !eoc);
    assert_tick_only_running_R2: assert property (@(posedge clk) disable iff (rst)
        tick |-> (phase != PH_IDLE));

endmodule

// File: tb/tb_carrier_gate_mod.sv
module tb_carrier_gate_mod;

    logic        clk = 1'b0;
    logic        rst;
    logic        mod_en, baseband_sel, fsk_sel, irq_en;
    logic [15:0] mark_val, space_val;
    logic        carrier_in, eoc_clr;
    logic        mod_out, eoc_flag, irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    carrier_gate_mod dut (
        .clk          (clk),
        .rst          (rst),
        .mod_en       (mod_en),
        .baseband_sel (baseband_sel),
        .fsk_sel      (fsk_sel),
        .irq_en       (irq_en),
        .mark_val     (mark_val),
        .space_val    (space_val),
        .carrier_in   (carrier_in),
        .eoc_clr      (eoc_clr),
        .mod_out      (mod_out),
        .eoc_flag     (eoc_flag),
        .irq          (irq)
    );

    // mark, space, expected mark clocks, expected cycle clocks
    localparam int NV = 7;
    localparam logic [63:0] VEC [NV] = '{
        {16'd0,   16'd0,   16'd8,    16'd8},
        {16'd0,   16'd1,   16'd8,    16'd16},
        {16'd2,   16'd3,   16'd24,   16'd48},
        {16'd5,   16'd0,   16'd48,   16'd48},
        {16'd1,   16'd7,   16'd16,   16'd72},
        {16'd10,  16'd2,   16'd88,   16'd104},
        {16'd255, 16'd255, 16'd2048, 16'd4088}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // leaves the bench at the negedge just before the start edge
    task automatic start_cfg(input logic [15:0] m, input logic [15:0] s);
        @(negedge clk);
        mod_en  = 1'b0;
        eoc_clr = 1'b1;
        @(negedge clk);
        eoc_clr   = 1'b0;
        mark_val  = m;
        space_val = s;
        mod_en    = 1'b1;
    endtask

    task automatic measure(input logic [15:0] m, input logic [15:0] s,
                           output int hi, output int total);
        int n = 0;
        int h = 0;
        start_cfg(m, s);
        forever begin
            @(negedge clk);
            n++;
            if (mod_out) h++;
            if (eoc_flag || n > 20000) break;
        end
        hi    = h - 1;
        total = n - 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int hi, tot;
        int bad;
        rst = 1'b1; mod_en = 1'b0; baseband_sel = 1'b0; fsk_sel = 1'b0;
        irq_en = 1'b1; mark_val = '0; space_val = '0; carrier_in = 1'b1;
        eoc_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 mod_out", int'(mod_out), 0);
        chk("R11 eoc_flag", int'(eoc_flag), 0);
        chk("R11 irq", int'(irq), 0);
        rst = 1'b0;

        // R2 R3 R4 R6 R8: table of lengths
        for (int i = 0; i < NV; i++) begin
            measure(VEC[i][63:48], VEC[i][47:32], hi, tot);
            chk($sformatf("R3 mark clocks vec%0d", i), hi, int'(VEC[i][31:16]));
            chk($sformatf("R4 cycle clocks vec%0d", i), tot, int'(VEC[i][15:0]));
            chk($sformatf("R2 multiple of 8 vec%0d", i), tot % 8, 0);
            chk($sformatf("R8 irq follows flag vec%0d", i), int'(irq), 1);
        end

        // R1: baseband or fsk select blocks time mode
        for (int sel = 0; sel < 2; sel++) begin
            start_cfg(16'd0, 16'd0);
            baseband_sel = (sel == 0);
            fsk_sel      = (sel == 1);
            bad = 0;
            repeat (100) begin
                @(negedge clk);
                if (mod_out || eoc_flag) bad++;
            end
            chk($sformatf("R1 blocked sel%0d", sel), bad, 0);
            baseband_sel = 1'b0;
            fsk_sel      = 1'b0;
        end

        // R5: carrier gating, mark samples 1..32, space 33..48
        start_cfg(16'd3, 16'd2);
        bad = 0;
        for (int k = 1; k <= 48; k++) begin
            @(negedge clk);
            carrier_in = k[0];
            #1;
            if (mod_out !== ((k <= 32) ? carrier_in : 1'b0)) bad++;
        end
        chk("R5 gating mismatches", bad, 0);
        carrier_in = 1'b1;

        // R9: values changed mid-cycle apply only to next cycle
        start_cfg(16'd0, 16'd1);
        for (int k = 1; k <= 57; k++) begin
            @(negedge clk);
            if (k == 3)  begin mark_val = 16'd1; space_val = 16'd3; end
            if (k == 9)  chk("R4 space low old value", int'(mod_out), 0);
            if (k == 16) chk("R9 first cycle not yet ended", int'(eoc_flag), 0);
            if (k == 17) begin chk("R9 first cycle uses old space", int'(eoc_flag), 1); eoc_clr = 1'b1; end
            if (k == 18) begin chk("R7 plain clear", int'(eoc_flag), 0); eoc_clr = 1'b0; end
            if (k == 32) chk("R9 new mark still high", int'(mod_out), 1);
            if (k == 33) chk("R9 new mark ended", int'(mod_out), 0);
            if (k == 56) chk("R9 new space not yet ended", int'(eoc_flag), 0);
            if (k == 57) chk("R9 new space ended", int'(eoc_flag), 1);
        end

        // R7 coincident set and clear, R8 irq masking
        start_cfg(16'd0, 16'd0);
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            if (k == 9)  chk("R6 flag after first cycle", int'(eoc_flag), 1);
            if (k == 10) begin irq_en = 1'b0; #1; chk("R8 irq masked", int'(irq), 0); irq_en = 1'b1; end
            if (k == 16) eoc_clr = 1'b1;
            if (k == 17) chk("R7 set wins over clear", int'(eoc_flag), 1);
            if (k == 18) begin chk("R7 clear after", int'(eoc_flag), 0); eoc_clr = 1'b0; end
        end

        // R10: disable mid-mark, then fresh mark
        start_cfg(16'd3, 16'd0);
        repeat (10) @(negedge clk);
        chk("R10 mark active before disable", int'(mod_out), 1);
        mod_en = 1'b0;
        #1;
        chk("R10 output low at once", int'(mod_out), 0);
        measure(16'd3, 16'd0, hi, tot);
        chk("R10 fresh mark length", hi, 32);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule